// File: doc/BRIEF.md
# OTP Page Load Command Sequencer

This block is a host-side controller for a NAND-type flash device. The device is reached through a 16-bit memory-mapped register bus. A single `start` pulse makes the block load the device's one-time-programmable area into the device's on-chip buffer. Each phase is made of register writes followed by polling of the interrupt status register.

In the first phase the block writes the die/block word and, for dual-die parts, the buffer die select. It then clears the interrupt register and issues the OTP access command. The OTP access command stands in for a real block address, so the block address value does not matter. In the second phase the block reuses the ordinary load path: it writes the page/sector word and the buffer sector/count word, then issues the load command. When that completes, the block raises `data_ready` and stays idle on the bus until the host pulses `host_done`. A reset command is then issued, because reset is the only way to leave OTP access mode. A one-cycle `done` pulse closes the run.

Every poll is bounded by a programmable cycle limit. If the limit expires, the run is abandoned with a one-cycle `err` pulse.

Top module: `otp_load_seq`

## Requirements
- R1: While `rst_n` is low and after reset, `busy`, `done`, `err`, `data_ready`, `bus_wr` and `bus_rd` are all 0.
- R2: After `start` in idle, the first writes are, in order:
  - address F100h with data `{die_sel, 5'b0, blk_addr[9:0]}`;
  - if `dual_die` = 1, address F101h with data `{buf_die, 15'b0}`;
  - if `auto_clr` = 0, address F241h with data 0000h;
  - address F220h with data 0065h (OTP access command).
- R3: After each command write, the block reads only address F241h. It repeats the read until a read returns bit 15 = 1, and it makes no write before that.
- R4: After the OTP access completes, the writes are, in order:
  - address F107h with data `{8'b0, page[5:0], sector[1:0]}`;
  - address F200h with data 0800h;
  - if `auto_clr` = 0, address F241h with data 0000h;
  - address F220h with data 0000h (load command).
- R5: After the load completes, `data_ready` = 1 and `busy` = 1 with no bus strobe. This holds until `host_done` is sampled high.
- R6: After `host_done`, the block writes:
  - if `auto_clr` = 0, address F241h with data 0000h;
  - address F220h with data 00F0h (reset command, parameter `RST_CMD`).

  It then polls as in R3. On completion `done` pulses for exactly one cycle and `busy` falls in that same cycle.
- R7: With `auto_clr` = 1, none of the three F241h clear writes occur.
- R8: With `dual_die` = 0, no write to F101h occurs.
- R9: If a poll has lasted `poll_limit` cycles without a read returning bit 15 = 1, then `err` pulses for one cycle, `busy` falls and no further bus access occurs. A successful read completing in the same cycle as expiry takes precedence over the timeout.
- R10: A strobe (`bus_wr` or `bus_rd`) stays high with stable address and data until `bus_ack` is sampled high, then drops in the next cycle. `bus_wr` and `bus_rd` are never high together.
- R11: `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load run when idle |
| die_sel | input | 1 | Flash die select for the block word |
| blk_addr | input | 10 | Block address field (ignored by the device in OTP mode) |
| buf_die | input | 1 | Buffer die select, dual-die parts |
| page | input | 6 | Page address |
| sector | input | 2 | Sector address |
| dual_die | input | 1 | 1 = write the buffer die select word |
| auto_clr | input | 1 | 1 = device clears its interrupt itself; skip clear writes |
| poll_limit | input | 16 | Poll timeout in cycles |
| host_done | input | 1 | Host finished reading the buffer |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 16 | Register write data |
| bus_rdata | input | 16 | Register read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer acknowledge |
| busy | output | 1 | Run in progress |
| data_ready | output | 1 | Buffer holds the OTP data |
| done | output | 1 | One-cycle run completion pulse |
| err | output | 1 | One-cycle poll timeout pulse |

## Verification
The two functions that can land in one cycle are poll timeout expiry and the acknowledge of a status read that reports completion. The bench provokes this by setting `poll_limit` to 1 and having the responder acknowledge the first status read immediately, so the acknowledge arrives exactly when the counter reaches the limit. The run must then finish normally with `done` and all expected writes. The same limit with completion delayed to the second read must instead end in `err`, with only the first phase's writes seen.

// File: rtl/otp_seq_pkg.sv
// Package: shared state type and the device register map used by the
// OTP load sequencer. Assumes a 16-bit register address space.
package otp_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_BLK, S_DBS, S_CLR1, S_OTP, S_POLL1,
        S_PAGE, S_BUF, S_CLR2, S_LOAD, S_POLL2,
        S_READY, S_CLR3, S_RST, S_POLL3
    } seq_state_t;

    localparam logic [15:0] REG_BLK   = 16'hF100;
    localparam logic [15:0] REG_DBS   = 16'hF101;
    localparam logic [15:0] REG_PAGE  = 16'hF107;
    localparam logic [15:0] REG_BUF   = 16'hF200;
    localparam logic [15:0] REG_CMD   = 16'hF220;
    localparam logic [15:0] REG_INT   = 16'hF241;

    localparam logic [15:0] CODE_OTP  = 16'h0065;
    localparam logic [15:0] CODE_LOAD = 16'h0000;
    localparam logic [15:0] BUF_WORD  = 16'h0800;
    localparam int          INT_BIT   = 15;

endpackage

// File: rtl/otp_bus_port.sv
// Bus port: runs one register transfer at a time. A request latches
// address, data and direction; the strobe stays high until bus_ack is
// sampled, then drops. Assumes the responder lowers bus_ack once the
// strobe is low. An abort drops a pending transfer at once.
module otp_bus_port #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          abort,
    input  logic          bus_ack,
    output logic          bus_wr,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          xfer_done
);

    logic active;
    logic is_wr;

    // Transfer holding register: capture on request, release on ack or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            is_wr     <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (abort) begin
            active    <= 1'b0;
        end else if (active && bus_ack) begin
            active    <= 1'b0;
        end else if (req) begin
            active    <= 1'b1;
            is_wr     <= req_wr;
            bus_addr  <= req_addr;
            bus_wdata <= req_data;
        end
    end

    // Strobes and completion derived from the holding register.
    always_comb begin
        bus_wr    = active && is_wr;
        bus_rd    = active && !is_wr;
        xfer_done = active && bus_ack;
    end

endmodule

// File: rtl/otp_poll_timer.sv
// Poll timer: counts cycles spent in a polling state and flags expiry
// once the count reaches the programmed limit. Clears outside polling.
module otp_poll_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_poll,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] cnt;

    // Saturating cycle counter, cleared whenever no poll is running.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!in_poll)       cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Expiry compare against the programmed limit.
    always_comb expired = in_poll && (cnt >= limit);

endmodule

// File: rtl/otp_seq_ctrl.sv
// Sequence controller: steps through the OTP access, load and exit
// phases, asking the bus port for one transfer per state and polling
// the interrupt register after each command. Assumes configuration
// inputs are held stable while busy.
module otp_seq_ctrl
    import otp_seq_pkg::*;
#(
    parameter logic [15:0] RST_CMD = 16'h00F0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        dual_die,
    input  logic        auto_clr,
    input  logic        host_done,
    input  logic [15:0] blk_word,
    input  logic [15:0] dbs_word,
    input  logic [15:0] page_word,
    input  logic        xfer_done,
    input  logic [15:0] rd_data,
    input  logic        expired,
    output logic        req,
    output logic        req_wr,
    output logic [15:0] req_addr,
    output logic [15:0] req_data,
    output logic        in_poll,
    output logic        abort,
    output logic        busy,
    output logic        data_ready,
    output logic        done,
    output logic        err
);

    seq_state_t state, nxt;
    logic       launched;
    logic       poll_hit;

    // Classify the current state and decide the abort condition.
    always_comb begin
        in_poll    = (state == S_POLL1) || (state == S_POLL2) || (state == S_POLL3);
        busy       = (state != S_IDLE);
        data_ready = (state == S_READY);
        poll_hit   = in_poll && xfer_done && rd_data[INT_BIT];
        abort      = in_poll && expired && !poll_hit;
        req        = busy && !data_ready && !launched;
    end

    // Transfer request contents for each state.
    always_comb begin
        req_wr   = 1'b1;
        req_addr = REG_INT;
        req_data = 16'h0000;
        case (state)
            S_BLK:  begin req_addr = REG_BLK;  req_data = blk_word;  end
            S_DBS:  begin req_addr = REG_DBS;  req_data = dbs_word;  end
            S_OTP:  begin req_addr = REG_CMD;  req_data = CODE_OTP;  end
            S_PAGE: begin req_addr = REG_PAGE; req_data = page_word; end
            S_BUF:  begin req_addr = REG_BUF;  req_data = BUF_WORD;  end
            S_LOAD: begin req_addr = REG_CMD;  req_data = CODE_LOAD; end
            S_RST:  begin req_addr = REG_CMD;  req_data = RST_CMD;   end
            S_POLL1, S_POLL2, S_POLL3: req_wr = 1'b0;
            default: ;
        endcase
    end

    // Successor of each state once its step has completed.
    always_comb begin
        case (state)
            S_IDLE:  nxt = S_BLK;
            S_BLK:   nxt = dual_die ? S_DBS : (auto_clr ? S_OTP : S_CLR1);
            S_DBS:   nxt = auto_clr ? S_OTP : S_CLR1;
            S_CLR1:  nxt = S_OTP;
            S_OTP:   nxt = S_POLL1;
            S_POLL1: nxt = S_PAGE;
            S_PAGE:  nxt = S_BUF;
            S_BUF:   nxt = auto_clr ? S_LOAD : S_CLR2;
            S_CLR2:  nxt = S_LOAD;
            S_LOAD:  nxt = S_POLL2;
            S_POLL2: nxt = S_READY;
            S_READY: nxt = auto_clr ? S_RST : S_CLR3;
            S_CLR3:  nxt = S_RST;
            S_RST:   nxt = S_POLL3;
            default: nxt = S_IDLE;
        endcase
    end

    // State register, launch flag and completion/error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            launched <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (abort) begin
                state    <= S_IDLE;
                launched <= 1'b0;
                err      <= 1'b1;
            end else if (state == S_IDLE) begin
                if (start) state <= nxt;
            end else if (state == S_READY) begin
                if (host_done) state <= nxt;
            end else if (xfer_done) begin
                launched <= 1'b0;
                if (!in_poll || poll_hit) begin
                    state <= nxt;
                    if (nxt == S_IDLE) done <= 1'b1;
                end
            end else if (req) begin
                launched <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/otp_load_seq.sv
// Top: OTP page load sequencer. Packs the select inputs into device
// register words and ties together controller, bus port and poll timer.
// Assumes FBA_W <= 15 and FPA_W + FSA_W <= 16.
module otp_load_seq #(
    parameter int          FBA_W   = 10,
    parameter int          FPA_W   = 6,
    parameter int          FSA_W   = 2,
    parameter int          TMO_W   = 16,
    parameter logic [15:0] RST_CMD = 16'h00F0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             die_sel,
    input  logic [FBA_W-1:0] blk_addr,
    input  logic             buf_die,
    input  logic [FPA_W-1:0] page,
    input  logic [FSA_W-1:0] sector,
    input  logic             dual_die,
    input  logic             auto_clr,
    input  logic [TMO_W-1:0] poll_limit,
    input  logic             host_done,
    output logic             bus_wr,
    output logic             bus_rd,
    output logic [15:0]      bus_addr,
    output logic [15:0]      bus_wdata,
    input  logic [15:0]      bus_rdata,
    input  logic             bus_ack,
    output logic             busy,
    output logic             data_ready,
    output logic             done,
    output logic             err
);

    localparam int BLK_PAD = 15 - FBA_W;
    localparam int PG_PAD  = 16 - FPA_W - FSA_W;

    logic [15:0] blk_word, dbs_word, page_word;
    logic        req, req_wr, in_poll, abort, expired, xfer_done;
    logic [15:0] req_addr, req_data;

    // Register word packing from the select inputs.
    always_comb begin
        blk_word  = {die_sel, {BLK_PAD{1'b0}}, blk_addr};
        dbs_word  = {buf_die, 15'h0000};
        page_word = {{PG_PAD{1'b0}}, page, sector};
    end

    otp_seq_ctrl #(.RST_CMD(RST_CMD)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dual_die   (dual_die),
        .auto_clr   (auto_clr),
        .host_done  (host_done),
        .blk_word   (blk_word),
        .dbs_word   (dbs_word),
        .page_word  (page_word),
        .xfer_done  (xfer_done),
        .rd_data    (bus_rdata),
        .expired    (expired),
        .req        (req),
        .req_wr     (req_wr),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .in_poll    (in_poll),
        .abort      (abort),
        .busy       (busy),
        .data_ready (data_ready),
        .done       (done),
        .err        (err)
    );

    otp_bus_port #(.AW(16), .DW(16)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .abort     (abort),
        .bus_ack   (bus_ack),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .xfer_done (xfer_done)
    );

    otp_poll_timer #(.TW(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_poll (in_poll),
        .limit   (poll_limit),
        .expired (expired)
    );

endmodule

// File: rtl/otp_load_seq_chk.sv
// Checker: port-level protocol properties of the OTP load sequencer,
// attached to every instance of the top by the bind below.
module otp_load_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        bus_ack,
    input logic [15:0] bus_addr,
    input logic [15:0] bus_wdata,
    input logic        busy,
    input logic        data_ready,
    input logic        done,
    input logic        err
);

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R10
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata))); // R10
    AST_STROBE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_ack) |=> (!bus_wr && !bus_rd)); // R10
    AST_READ_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_addr == 16'hF241)); // R3
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> (busy && !bus_wr && !bus_rd)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done)); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done && !err) |=> (busy || done || err)); // R11

endmodule

bind otp_load_seq otp_load_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_ack    (bus_ack),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .data_ready (data_ready),
    .done       (done),
    .err        (err)
);

// File: tb/tb_otp_load_seq.sv
// Bench: scoreboard of expected register writes pushed by driver tasks,
// popped and compared by the bus responder/monitor as writes complete.
module tb_otp_load_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, die_sel, buf_die, dual_die, auto_clr, host_done;
    logic [9:0]  blk_addr;
    logic [5:0]  page;
    logic [1:0]  sector;
    logic [15:0] poll_limit;
    logic        bus_wr, bus_rd, bus_ack;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        busy, data_ready, done, err;

    int nchk = 0;
    int nerr = 0;

    typedef struct {
        logic [15:0] a;
        logic [15:0] d;
        string       rq;
    } exp_t;
    exp_t exp_q[$];

    // Responder knobs
    int ack_wait  = 0;
    int int_delay = 1;
    bit int_never = 0;
    int reads_since = 0;
    int wcnt = 0;
    logic [15:0] first_a, first_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_load_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .die_sel(die_sel),
        .blk_addr(blk_addr), .buf_die(buf_die), .page(page), .sector(sector),
        .dual_die(dual_die), .auto_clr(auto_clr), .poll_limit(poll_limit),
        .host_done(host_done), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .busy(busy), .data_ready(data_ready),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic [15:0] d, input string rq);
        exp_t e;
        e.a = a; e.d = d; e.rq = rq;
        exp_q.push_back(e);
    endtask

    // R2 / R7 / R8: OTP access phase writes
    task automatic push_phase1();
        push(16'hF100, {die_sel, 5'b0, blk_addr}, "R2");
        if (dual_die) push(16'hF101, {buf_die, 15'b0}, "R8");
        if (!auto_clr) push(16'hF241, 16'h0000, "R7");
        push(16'hF220, 16'h0065, "R2");
    endtask

    // R4: load phase writes
    task automatic push_phase2();
        push(16'hF107, {8'b0, page, sector}, "R4");
        push(16'hF200, 16'h0800, "R4");
        if (!auto_clr) push(16'hF241, 16'h0000, "R7");
        push(16'hF220, 16'h0000, "R4");
    endtask

    // R6: exit phase writes
    task automatic push_phase3();
        if (!auto_clr) push(16'hF241, 16'h0000, "R7");
        push(16'hF220, 16'h00F0, "R6");
    endtask

    // Monitor and responder: acks strobes, pops and compares writes,
    // answers status reads with bit 15 per the int_delay knob.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0;
            wcnt = 0;
        end else if ((bus_wr || bus_rd) && !bus_ack) begin
            if (wcnt == 0) begin
                first_a = bus_addr;
                first_d = bus_wdata;
            end
            if (wcnt < ack_wait) begin
                wcnt++;
            end else begin
                if (ack_wait > 0)
                    chk(first_a == bus_addr && first_d == bus_wdata, "R10",
                        "strobe fields held", {bus_addr, bus_wdata}, {first_a, first_d});
                if (bus_wr) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2", "unexpected write", {bus_addr, bus_wdata}, 32'h0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(bus_addr == e.a && bus_wdata == e.d, e.rq, "write",
                            {bus_addr, bus_wdata}, {e.a, e.d});
                    end
                    if (bus_addr == 16'hF220) reads_since = 0;
                end else begin
                    chk(bus_addr == 16'hF241, "R3", "read address", {16'h0, bus_addr}, 32'hF241);
                    bus_rdata = {(!int_never && (reads_since + 1 >= int_delay)), 15'h0};
                    reads_since++;
                end
                bus_ack = 1'b1;
                wcnt = 0;
            end
        end else begin
            bus_ack = 1'b0;
            wcnt = 0;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic wait_end(output bit gd, output bit ge, input int maxc);
        gd = 0; ge = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (done) begin gd = 1; return; end
            if (err)  begin ge = 1; return; end
        end
    endtask

    task automatic setup(input bit dd, input bit ac, input logic dsel,
                         input logic [9:0] fba, input logic bdie,
                         input logic [5:0] pg, input logic [1:0] sc,
                         input int idly, input int aw, input logic [15:0] lim);
        @(negedge clk);
        dual_die = dd; auto_clr = ac; die_sel = dsel; blk_addr = fba;
        buf_die = bdie; page = pg; sector = sc; int_delay = idly;
        ack_wait = aw; poll_limit = lim; int_never = 0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_full();
        bit gd, ge, seen;
        int strobes;
        push_phase1();
        push_phase2();
        push_phase3();
        pulse_start();
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (data_ready || err) seen = 1;
        end
        chk(data_ready && busy, "R5", "data_ready after load", {30'h0, data_ready, busy}, 32'h3);
        // R11: start while busy must be ignored; R5: bus quiet while ready
        start = 1'b1;
        strobes = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (bus_wr || bus_rd) strobes++;
        end
        chk(strobes == 0, "R5", "strobes while ready", strobes, 0);
        chk(data_ready == 1'b1, "R11", "still waiting for host", {31'h0, data_ready}, 32'h1);
        host_done = 1'b1;
        @(negedge clk);
        host_done = 1'b0;
        wait_end(gd, ge, 3000);
        chk(gd && !ge, "R6", "done after exit", {30'h0, gd, ge}, 32'h2);
        chk(!busy, "R6", "busy low with done", {31'h0, busy}, 32'h0);
        @(negedge clk);
        chk(!done, "R6", "done one cycle", {31'h0, done}, 32'h0);
        chk(exp_q.size() == 0, "R6", "writes left in scoreboard", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic run_timeout();
        bit gd, ge;
        int strobes;
        push_phase1();
        pulse_start();
        wait_end(gd, ge, 3000);
        chk(ge && !gd, "R9", "err on timeout", {30'h0, gd, ge}, 32'h1);
        chk(!busy, "R9", "busy low with err", {31'h0, busy}, 32'h0);
        strobes = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (bus_wr || bus_rd) strobes++;
        end
        chk(strobes == 0, "R9", "bus quiet after timeout", strobes, 0);
        chk(exp_q.size() == 0, "R9", "writes left in scoreboard", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; host_done = 1'b0;
        die_sel = 0; blk_addr = '0; buf_die = 0; page = '0; sector = '0;
        dual_die = 0; auto_clr = 0; poll_limit = 16'd100;
        bus_rdata = '0; bus_ack = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !err && !data_ready && !bus_wr && !bus_rd, "R1", "outputs in reset",
            {26'h0, busy, done, err, data_ready, bus_wr, bus_rd}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !bus_wr && !bus_rd, "R1", "idle after reset",
            {29'h0, busy, bus_wr, bus_rd}, 32'h0);

        // R2 R4 R6 R8: dual die, explicit clears, slow interrupt
        setup(1, 0, 1, 10'h2A5, 1, 6'h2D, 2'd3, 3, 0, 16'd200);
        run_full();

        // R7 R8 R10: single die, auto clear, stretched acknowledge
        setup(0, 1, 0, 10'h3FF, 0, 6'h11, 2'd1, 2, 2, 16'd200);
        run_full();

        // R9: interrupt never arrives
        setup(1, 0, 0, 10'h001, 1, 6'h01, 2'd0, 1, 0, 16'd20);
        int_never = 1;
        run_timeout();

        // R9: completion coincides with expiry, completion wins
        setup(0, 0, 1, 10'h155, 0, 6'h3F, 2'd2, 1, 0, 16'd1);
        run_full();

        // R9: same limit, completion one read later, timeout wins
        setup(0, 1, 1, 10'h0F0, 0, 6'h05, 2'd1, 2, 0, 16'd1);
        run_timeout();

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule